// File: doc/BRIEF.md
# Bit-Plane Routing Network

This block moves bit-serial data from sixteen input shift registers into sixteen output shift registers over a single shared one-bit bus. Two eight-way selectors face the bus. Each selector serves half of the input registers, and at any moment exactly one of them is enabled. A four-to-sixteen distributor takes the bus bit and shifts it into one addressed output register. While it does so, every other output register holds its contents.

A counter-based address sequencer walks the selectors through all sixteen sources for each bit position. The input registers advance by one bit, MSB first, only after every source has been visited. This means one complete bit plane is gathered before the next one appears. The routing pattern is chosen at load time:
- **Plane mode** writes bit plane p into output register p. Output register 0 collects every input's MSB, output register 1 every next bit, and so on. The result is a corner turn (transpose).
- **Pass mode** writes each source back into the output register with the same index, which copies the data unchanged.

A load pulse captures all input words and starts a run. A run takes 256 routing cycles and ends with a done flag.

Top module: `bitplane_router`

## Requirements
- R1: After reset, every output register reads zero, and `busy` and `done` are both low.
- R2: A cycle with `load` high captures `load_data` (input register k is bits [16k+15:16k]) and clears all output registers. From the next cycle `busy` is 1 and `done` is 0.
- R3: With `mode`=1 (plane) at load, after the run, bit 15-k of output register p equals bit 15-p of input register k.
- R4: With `mode`=0 (pass) at load, after the run, output register k equals input register k.
- R5: `busy` stays high for exactly 256 cycles after the load cycle. On the cycle after that, `done` is 1 and `busy` is 0.
- R6: In each routing cycle only the addressed output register shifts. After the first 16 routing cycles in plane mode, only output register 0 holds data, and it holds every input's MSB, with input 0 at bit 15.
- R7: Only one selector drives the bus. Registers 0-7 are served by one selector and 8-15 by the other, chosen by the top bit of the source index.
- R8: `mode` is sampled only in the load cycle. Changing it during a run does not change the result.
- R9: A load during a run abandons that run and starts a new one from the new data.
- R10: Once `done` is high, the output registers and `done` hold until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture `load_data` and start a run |
| mode | input | 1 | Routing pattern: 1 plane (transpose), 0 pass |
| load_data | input | 256 | Sixteen 16-bit input words, register k at [16k+15:16k] |
| out_data | output | 256 | Sixteen 16-bit output words, register k at [16k+15:16k] |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, outputs valid |

## Verification
The design is exercised with several input patterns, each in both modes, and each pattern tells different faults apart:
- **Diagonal one-hot pattern:** separates a transpose from a copy, because the two modes give visibly different results.
- **Half-ones / half-zeros pattern (registers 0-7 versus 8-15):** exposes a swapped or doubly enabled selector.
- **Distinct per-register words:** catch bit-order and source-index mistakes.
- **All-ones pattern:** exposes dropped shifts.

A check partway through a plane-mode run confirms that only the first output register has moved. Separate runs cover a mode change during a run and a restart from a second load during a run.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  typedef enum logic {
    RT_PASS  = 1'b0,
    RT_PLANE = 1'b1
  } route_mode_t;
endpackage

// File: rtl/bpr_sequencer.sv
module bpr_sequencer #(
  parameter int NREG  = 16,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     mode_in,
  output logic [$clog2(NREG)-1:0]  src_idx,
  output logic [$clog2(NREG)-1:0]  dst_idx,
  output logic                     in_shift,
  output logic                     busy,
  output logic                     done
);
  import bpr_pkg::*;
  localparam int SRC_W = $clog2(NREG);
  localparam int BIT_W = $clog2(WIDTH);
  localparam int CNT_W = SRC_W + BIT_W;
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};
  localparam logic [SRC_W-1:0] SRC_LAST = {SRC_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic busy_q, busy_n, done_q, done_n;
  route_mode_t mode_q, mode_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = done_q;
    mode_n = mode_q;
    if (load) begin
      cnt_n  = '0;
      busy_n = 1'b1;
      done_n = 1'b0;
      mode_n = route_mode_t'(mode_in);
    end else if (busy_q) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= RT_PASS;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      mode_q <= mode_n;
    end
  end

  logic [SRC_W-1:0] plane_idx;
  assign src_idx   = cnt_q[SRC_W-1:0];
  assign plane_idx = SRC_W'(cnt_q[CNT_W-1:SRC_W]);
  assign dst_idx   = (mode_q == RT_PLANE) ? plane_idx : src_idx;
  assign in_shift  = busy_q && !load && (src_idx == SRC_LAST);
  assign busy      = busy_q;
  assign done      = done_q;

  // R5: the last routing cycle leads straight into done
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load && cnt_q == LAST) |=> (done_q && !busy_q));
  // R5: done and busy never both high
  a_r5_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R8: routing pattern frozen during a run
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load) |=> $stable(mode_q));
  // R10: done holds while idle
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load) |=> done_q);
endmodule

// File: rtl/bpr_source.sv
module bpr_source #(
  parameter int NREG  = 16,
  parameter int WIDTH = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [NREG-1:0][WIDTH-1:0]         load_data,
  input  logic                               shift_en,
  input  logic [$clog2(NREG)-1:0]            src_idx,
  output logic                               bus_bit
);
  localparam int SRC_W  = $clog2(NREG);
  localparam int GROUPS = 2;
  localparam int GRP    = NREG / GROUPS;
  localparam int ADR_W  = SRC_W - 1;

  logic [NREG-1:0][WIDTH-1:0] in_q, in_n;

  always_comb begin
    in_n = in_q;
    if (load) begin
      in_n = load_data;
    end else if (shift_en) begin
      for (int k = 0; k < NREG; k++) in_n[k] = {in_q[k][WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else        in_q <= in_n;
  end

  logic [NREG-1:0]   msb;
  logic [GROUPS-1:0] grp_en;
  logic [GROUPS-1:0] grp_out;
  logic [ADR_W-1:0]  sel_adr;

  assign sel_adr = src_idx[ADR_W-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_msb
    assign msb[k] = in_q[k][WIDTH-1];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_sel
    logic [GRP-1:0] leg;
    assign leg        = msb[g*GRP +: GRP];
    assign grp_en[g]  = (src_idx[SRC_W-1] == 1'(g));
    assign grp_out[g] = grp_en[g] & leg[sel_adr];
  end

  assign bus_bit = |grp_out;

  // R7: one selector on the bus
  a_r7_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(grp_en));
  // R3: input registers move only at the end of a plane
  a_r3_inputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(in_q));
endmodule

// File: rtl/bpr_distributor.sv
module bpr_distributor #(
  parameter int NREG = 16
) (
  input  logic                    strobe,
  input  logic [$clog2(NREG)-1:0] addr,
  output logic [NREG-1:0]         line_en
);
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign line_en[i] = strobe && (addr == ($clog2(NREG))'(i));
  end
endmodule

// File: rtl/bpr_sink.sv
module bpr_sink #(
  parameter int NREG  = 16,
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic [NREG-1:0]            line_en,
  input  logic                       bus_bit,
  output logic [NREG-1:0][WIDTH-1:0] out_q
);
  logic [NREG-1:0][WIDTH-1:0] out_n;

  always_comb begin
    out_n = out_q;
    if (clear) begin
      out_n = '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (line_en[i]) out_n[i] = {out_q[i][WIDTH-2:0], bus_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_n;
  end

  // R6: at most one output register shifts per cycle
  a_r6_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_en));
  for (genvar i = 0; i < NREG; i++) begin : g_hold
    // R6: unaddressed registers keep their contents
    a_r6_unaddressed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !line_en[i]) |=> $stable(out_q[i]));
  end
endmodule

// File: rtl/bitplane_router.sv
module bitplane_router #(
  parameter int NREG  = 16,
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  mode,
  input  logic [NREG*WIDTH-1:0] load_data,
  output logic [NREG*WIDTH-1:0] out_data,
  output logic                  busy,
  output logic                  done
);
  localparam int SRC_W = $clog2(NREG);

  logic [SRC_W-1:0] src_idx, dst_idx;
  logic             in_shift, bus_bit, strobe;
  logic [NREG-1:0]  line_en;
  logic [NREG-1:0][WIDTH-1:0] in_words, out_words;

  assign in_words = load_data;
  assign out_data = out_words;
  assign strobe   = busy && !load;

  bpr_sequencer #(.NREG(NREG), .WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .mode_in(mode),
    .src_idx(src_idx), .dst_idx(dst_idx), .in_shift(in_shift),
    .busy(busy), .done(done));

  bpr_source #(.NREG(NREG), .WIDTH(WIDTH)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(in_words),
    .shift_en(in_shift), .src_idx(src_idx), .bus_bit(bus_bit));

  bpr_distributor #(.NREG(NREG)) u_dist (
    .strobe(strobe), .addr(dst_idx), .line_en(line_en));

  bpr_sink #(.NREG(NREG), .WIDTH(WIDTH)) u_sink (
    .clk(clk), .rst_n(rst_n), .clear(load), .line_en(line_en),
    .bus_bit(bus_bit), .out_q(out_words));

  // R2: a load starts a fresh run
  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !done));
endmodule

// File: tb/bitplane_router_test.sv
module bitplane_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic mode = 1'b0;
  logic [255:0] load_data = '0;
  logic [255:0] out_data;
  logic busy, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [255:0] expq[$];
  logic         modeq[$];

  always #4 clk = ~clk;

  bitplane_router uut (
    .clk(clk), .rst_n(rst_n), .load(load), .mode(mode),
    .load_data(load_data), .out_data(out_data), .busy(busy), .done(done));

  function automatic logic [255:0] model(input logic [255:0] d, input logic m);
    logic [255:0] r;
    r = '0;
    for (int k = 0; k < 16; k++)
      for (int p = 0; p < 16; p++)
        if (m) r[16*p + (15-k)] = d[16*k + (15-p)];
        else   r[16*k + (15-p)] = d[16*k + (15-p)];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: start a run, optionally push its expected image
  task automatic start(input logic [255:0] d, input logic m, input bit push);
    @(negedge clk);
    load = 1'b1; load_data = d; mode = m;
    if (push) begin
      expq.push_back(model(d, m));
      modeq.push_back(m);
    end
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each finished run with the scoreboard
  bit seen = 1'b0;
  initial forever begin
    @(negedge clk);
    if (busy) seen = 1'b0;
    if (rst_n && done && !seen) begin
      logic [255:0] e;
      logic m;
      seen = 1'b1;
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 unexpected done act=1 exp=0");
      end else begin
        e = expq.pop_front();
        m = modeq.pop_front();
        for (int r = 0; r < 16; r++)
          chk(m ? "R3 plane reg" : "R4 pass reg",
              {240'b0, out_data[16*r +: 16]}, {240'b0, e[16*r +: 16]});
      end
    end
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    total++; bad++;
    $display("FAIL watchdog act=%0d exp<150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] diag, grp, cnt, ones, d1, d2, r6exp;
    for (int k = 0; k < 16; k++) begin
      diag[16*k +: 16] = 16'h8000 >> k;
      grp[16*k +: 16]  = (k < 8) ? 16'hFFFF : 16'h0000;
      cnt[16*k +: 16]  = 16'(k * 16'h1357 + 16'h0A5C);
      ones[16*k +: 16] = 16'hFFFF;
      d1[16*k +: 16]   = 16'(16'hC3A5 ^ (k * 16'h0F1D));
      d2[16*k +: 16]   = 16'(16'h5AA5 + k * 16'h2211);
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out", out_data, '0);
    chk("R1 busy/done", {254'b0, busy, done}, '0);
    rst_n = 1'b1;

    // R2 and R5 timing on a plane run
    start(diag, 1'b1, 1'b1);
    chk("R2 busy/done after load", {254'b0, busy, done}, {254'b0, 2'b10});
    chk("R2 out cleared", out_data, '0);
    repeat (255) @(negedge clk);
    chk("R5 still busy at 256th cycle", {254'b0, busy, done}, {254'b0, 2'b10});
    @(negedge clk);
    chk("R5 done after 256 cycles", {254'b0, busy, done}, {254'b0, 2'b01});
    // R10 hold after done
    repeat (20) @(negedge clk);
    chk("R10 out held", out_data, model(diag, 1'b1));
    chk("R10 done held", {255'b0, done}, 256'd1);

    start(diag, 1'b0, 1'b1); wait_done();
    // R7 selector halves in both modes
    start(grp, 1'b1, 1'b1); wait_done();
    start(grp, 1'b0, 1'b1); wait_done();
    start(cnt, 1'b1, 1'b1); wait_done();
    start(cnt, 1'b0, 1'b1); wait_done();
    start(ones, 1'b1, 1'b1); wait_done();

    // R6 partial plane run: only output register 0 moved
    start(d1, 1'b1, 1'b0);
    repeat (16) @(negedge clk);
    r6exp = '0;
    for (int k = 0; k < 16; k++) r6exp[15-k] = d1[16*k + 15];
    chk("R6 only reg0 after first plane", out_data, r6exp);
    // R9 reload during run restarts
    start(d2, 1'b0, 1'b1);
    wait_done();

    // R8 mode change during a run has no effect
    start(d1, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    mode = 1'b0;
    wait_done();
    chk("R8 final image", out_data, model(d1, 1'b1));

    repeat (4) @(negedge clk);
    chk("R5 scoreboard drained", {224'b0, 32'(expq.size())}, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule